// File: doc/BRIEF.md
# Dual-Lane Receive Word Buffer with Half-Word Host Readout

This block buffers 32-bit serial-bus words for a set of independent receive lanes (two by default) and hands them to a host over a 16-bit bus. Each lane takes filtered words from its receive path, one word per `wr_valid` pulse. It holds up to 32 of them in arrival order. Three active-low status outputs per lane tell the host whether data is waiting, whether the lane is at least half full and whether it is completely full.

The host picks a lane with that lane's enable bit and reads the oldest word in two strobes. With `rd_sel` low, a strobe returns bits 15:0. With `rd_sel` high, it returns bits 31:16, and only this second strobe retires the word. When a full lane receives another word, the newest stored word is replaced, so the buffer always ends with the most recent arrival. The read half appears on `rd_data` one clock after the strobe.

Top module: `rx_word_buffer`

## Requirements
- R1: After reset every `ready_n`, `full_n` and `half_n` bit is 1 and `rd_data` is 0.
- R2: One clock edge after a lane accepts a word on `wr_valid`, that lane's `ready_n` is 0.
- R3: A strobe with `rd_sel`=0 puts bits 15:0 of the lane's oldest word on `rd_data` after the next edge. It retires nothing, so repeating it returns the same half.
- R4: A strobe with `rd_sel`=1 puts bits 31:16 of the oldest word on `rd_data` after the next edge and retires that word. `ready_n` returns to 1 once the last word has been retired.
- R5: Words are read out in the order they were written.
- R6: A lane's `full_n` is 0 exactly when it holds 32 words.
- R7: A word that arrives at a full lane, with no retiring read in the same cycle, replaces the newest stored word. The other 31 words are left intact and the lane stays full.
- R8: A lane's `half_n` is 0 exactly when it holds 16 or more words.
- R9: A strobe to an empty lane leaves `rd_data` unchanged and moves no pointer. The next word written is the next word read.
- R10: Lanes are independent. A write or read on one lane leaves the other lanes' flags and contents unchanged, and `rd_data` shows the lane that received the most recent strobe. At most one enable bit may be high at a time.
- R11: A word that arrives at a full lane in the same cycle as a retiring read is appended normally. The lane stays full and nothing is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | NUM_RX | Per-lane pulse: a new word is presented |
| wr_word | input | NUM_RX*32 | Per-lane word, lane k in bits 32k+31:32k |
| rd_en | input | NUM_RX | Per-lane read strobe, one-hot or zero |
| rd_sel | input | 1 | 0 selects bits 15:0, 1 selects bits 31:16 and retires the word |
| rd_data | output | 16 | Half-word returned by the last strobe |
| ready_n | output | NUM_RX | Low while the lane holds at least one word |
| full_n | output | NUM_RX | Low while the lane holds 32 words |
| half_n | output | NUM_RX | Low while the lane holds 16 or more words |

## Verification
The assertions check on every cycle how the occupancy count moves. A low-half read never changes it. A high-half read on a non-empty lane lowers it by one. An empty-lane read freezes both the pointers and the returned data. A full lane that takes a word without a retire stays full with its write pointer held. The assertions also check that the full flag implies the half-full and ready flags, and that the lane enables are never high together. Only the bench scenarios can show data-level behaviour: that the word placed in the last slot on overflow is the newest one, that the 31 older words survive it, that the order of arrival is kept, and that the shared bus follows the lane last strobed.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned RXB_WORD_W = 32;
  localparam int unsigned RXB_HALF_W = RXB_WORD_W / 2;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl #(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned HALF_MARK = 16,
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic             wr_fire,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_fire,
  output logic [PTR_W-1:0] rd_addr,
  output logic             is_empty,
  output logic             is_full,
  output logic             is_half
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF_MARK);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, wr_prev;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             retire, overwrite, push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    is_empty  = (cnt_q == '0);
    is_full   = (cnt_q == FULL_CNT);
    is_half   = (cnt_q >= HALF_CNT);
    retire    = rd_en & rd_sel & ~is_empty;
    rd_fire   = rd_en & ~is_empty;
    overwrite = wr_valid & is_full & ~retire;
    push      = wr_valid & ~overwrite;
    wr_prev   = (wr_ptr_q == '0) ? LAST_PTR : wr_ptr_q - PTR_W'(1);
    wr_fire   = wr_valid;
    wr_addr   = overwrite ? wr_prev : wr_ptr_q;
    rd_addr   = rd_ptr_q;
    wr_ptr_d  = push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d  = retire ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d     = cnt_q;
    if (push && !retire) cnt_d = cnt_q + CNT_W'(1);
    else if (!push && retire) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // R3: a low-half read alone never changes occupancy
  a_r3_low_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !wr_valid) |=> $stable(cnt_q));
  // R4: a high-half read alone on a non-empty lane retires one word
  a_r4_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && cnt_q != '0 && !wr_valid) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R7: a word at a full lane without retire keeps it full, write pointer held
  a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL_CNT && wr_valid && !(rd_en && rd_sel)) |=> (cnt_q == FULL_CNT && $stable(wr_ptr_q)));
  // R9: a read of an empty lane moves no pointer
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && rd_en && !wr_valid) |=> ($stable(rd_ptr_q) && cnt_q == '0));
  // R11: simultaneous write and retire at full keeps the lane full
  a_r11_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL_CNT && wr_valid && rd_en && rd_sel) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned WORD_W = rxb_pkg::RXB_WORD_W,
  localparam int unsigned HALF_W = rxb_pkg::RXB_HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_fire,
  input  logic [PTR_W-1:0]  rd_addr,
  input  logic              rd_sel,
  output logic [HALF_W-1:0] rd_q
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;
  logic [HALF_W-1:0] rd_d;

  always_comb begin
    rd_word = mem[rd_addr];
    rd_d    = (rd_sel == rxb_pkg::HALF_HI) ? rd_word[WORD_W-1:HALF_W] : rd_word[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_fire) rd_q <= rd_d;
  end

  // R9: without an accepted read the returned half is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_q));
endmodule

// File: rtl/rxb_lane.sv
module rxb_lane #(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned HALF_MARK = 16,
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned WORD_W   = rxb_pkg::RXB_WORD_W,
  localparam int unsigned HALF_W   = rxb_pkg::RXB_HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [HALF_W-1:0] rd_q,
  output logic              ready_n,
  output logic              full_n,
  output logic              half_n
);
  logic             wr_fire, rd_fire, is_empty, is_full, is_half;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  rxb_ctrl #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en), .rd_sel(rd_sel),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .rd_fire(rd_fire), .rd_addr(rd_addr),
    .is_empty(is_empty), .is_full(is_full), .is_half(is_half)
  );

  rxb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_word(wr_word),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_sel(rd_sel), .rd_q(rd_q)
  );

  assign ready_n = is_empty;
  assign full_n  = ~is_full;
  assign half_n  = ~is_half;
endmodule

// File: rtl/rx_word_buffer.sv
module rx_word_buffer #(
  parameter int unsigned NUM_RX    = 2,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned HALF_MARK = 16,
  localparam int unsigned WORD_W   = rxb_pkg::RXB_WORD_W,
  localparam int unsigned HALF_W   = rxb_pkg::RXB_HALF_W,
  localparam int unsigned LANE_W   = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_RX-1:0]        wr_valid,
  input  logic [NUM_RX*WORD_W-1:0] wr_word,
  input  logic [NUM_RX-1:0]        rd_en,
  input  logic                     rd_sel,
  output logic [HALF_W-1:0]        rd_data,
  output logic [NUM_RX-1:0]        ready_n,
  output logic [NUM_RX-1:0]        full_n,
  output logic [NUM_RX-1:0]        half_n
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [HALF_W-1:0] lane_q [NUM_RX];
  logic [LANE_W-1:0] lane_sel_q, lane_sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  for (genvar k = 0; k < NUM_RX; k++) begin : g_lane
    rxb_lane #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_lane (
      .clk(clk), .rst_n(rst_n_int), .wr_valid(wr_valid[k]),
      .wr_word(wr_word[k*WORD_W +: WORD_W]), .rd_en(rd_en[k]), .rd_sel(rd_sel),
      .rd_q(lane_q[k]), .ready_n(ready_n[k]), .full_n(full_n[k]), .half_n(half_n[k])
    );
  end

  always_comb begin
    lane_sel_d = lane_sel_q;
    for (int k = NUM_RX - 1; k >= 0; k--) begin
      if (rd_en[k]) lane_sel_d = LANE_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) lane_sel_q <= '0;
    else if (|rd_en) lane_sel_q <= lane_sel_d;
  end

  assign rd_data = lane_q[lane_sel_q];

  // R10: the host strobes at most one lane at a time
  a_r10_one_lane: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(rd_en));
  // R6, R8: a full lane is also half full and holds data
  a_r6_full_implies: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((~full_n & (half_n | ready_n)) == '0));
endmodule

// File: tb/rx_word_buffer_test.sv
module rx_word_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRX = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NRX-1:0]  wr_valid;
  logic [NRX*32-1:0] wr_word;
  logic [NRX-1:0]  rd_en;
  logic            rd_sel;
  logic [15:0]     rd_data;
  logic [NRX-1:0]  ready_n, full_n, half_n;

  int total = 0;
  int bad = 0;

  rx_word_buffer uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .ready_n(ready_n), .full_n(full_n), .half_n(half_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return 32'hA000_0000 + i * 32'h0001_0003 + salt * 32'h0100_0100;
  endfunction

  // drive at negedge, edge captures, return at next negedge
  task automatic put(input int lane, input logic [31:0] w);
    wr_valid[lane] = 1'b1;
    wr_word[lane*32 +: 32] = w;
    @(negedge clk);
    wr_valid = '0;
  endtask

  task automatic get(input int lane, input logic sel, output logic [15:0] v);
    rd_en[lane] = 1'b1;
    rd_sel = sel;
    @(negedge clk);
    rd_en = '0;
    v = rd_data;
  endtask

  task automatic get_word(input int lane, input string req, input logic [31:0] exp);
    logic [15:0] lo, hi;
    get(lane, 1'b0, lo);
    get(lane, 1'b1, hi);
    chk(req, {hi, lo}, exp);
  endtask

  task automatic t_reset();
    chk("R1 ready_n", 32'(ready_n), 32'(2'b11));
    chk("R1 full_n", 32'(full_n), 32'(2'b11));
    chk("R1 half_n", 32'(half_n), 32'(2'b11));
    chk("R1 rd_data", 32'(rd_data), 32'h0);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    put(0, 32'h1234_5678);
    chk("R2 ready_n low", 32'(ready_n[0]), 32'h0);
    get(0, 1'b0, v);
    chk("R3 low half", 32'(v), 32'h5678);
    chk("R3 not retired", 32'(ready_n[0]), 32'h0);
    get(0, 1'b0, v);
    chk("R3 low half repeat", 32'(v), 32'h5678);
    get(0, 1'b1, v);
    chk("R4 high half", 32'(v), 32'h1234);
    chk("R4 ready_n high", 32'(ready_n[0]), 32'h1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) put(0, pat(i, 1));
    for (int i = 0; i < 3; i++) get_word(0, "R5 order", pat(i, 1));
    chk("R5 drained", 32'(ready_n[0]), 32'h1);
  endtask

  task automatic t_empty();
    logic [15:0] v;
    get(0, 1'b0, v);
    chk("R9 held data", 32'(v), 32'(pat(2, 1) >> 16));
    get(0, 1'b1, v);
    chk("R9 held data high", 32'(v), 32'(pat(2, 1) >> 16));
    put(0, 32'hCAFE_F00D);
    get_word(0, "R9 next word", 32'hCAFE_F00D);
  endtask

  task automatic t_fill_overwrite();
    for (int i = 0; i < 32; i++) begin
      put(0, pat(i, 2));
      if (i == 14) chk("R8 half_n at 15", 32'(half_n[0]), 32'h1);
      if (i == 15) chk("R8 half_n at 16", 32'(half_n[0]), 32'h0);
      if (i == 30) chk("R6 full_n at 31", 32'(full_n[0]), 32'h1);
    end
    chk("R6 full_n at 32", 32'(full_n[0]), 32'h0);
    chk("R10 lane1 untouched", 32'(ready_n[1]), 32'h1);
    put(0, 32'hDEAD_BEEF);
    chk("R7 still full", 32'(full_n[0]), 32'h0);
    for (int i = 0; i < 31; i++) begin
      get_word(0, "R7 older intact", pat(i, 2));
      if (i == 0) chk("R6 full_n released", 32'(full_n[0]), 32'h1);
      if (i == 16) chk("R8 half_n at 15 left", 32'(half_n[0]), 32'h1);
    end
    get_word(0, "R7 newest in last slot", 32'hDEAD_BEEF);
    chk("R7 drained", 32'(ready_n[0]), 32'h1);
  endtask

  task automatic t_full_swap();
    logic [15:0] v;
    for (int i = 0; i < 32; i++) put(0, pat(i, 3));
    get(0, 1'b0, v);
    chk("R11 low half", 32'(v), 32'(pat(0, 3) & 32'hFFFF));
    wr_valid[0] = 1'b1;
    wr_word[31:0] = 32'h7777_AAAA;
    rd_en[0] = 1'b1;
    rd_sel = 1'b1;
    @(negedge clk);
    wr_valid = '0;
    rd_en = '0;
    chk("R11 high half", 32'(rd_data), 32'(pat(0, 3) >> 16));
    chk("R11 still full", 32'(full_n[0]), 32'h0);
    for (int i = 1; i < 32; i++) get_word(0, "R11 kept", pat(i, 3));
    get_word(0, "R11 appended", 32'h7777_AAAA);
  endtask

  task automatic t_lanes();
    logic [15:0] v;
    put(1, 32'h4321_8765);
    chk("R10 lane1 ready", 32'(ready_n[1]), 32'h0);
    chk("R10 lane0 empty", 32'(ready_n[0]), 32'h1);
    put(0, 32'h0F0F_1E1E);
    get(1, 1'b0, v);
    chk("R10 lane1 low", 32'(v), 32'h8765);
    get(0, 1'b0, v);
    chk("R10 lane0 low", 32'(v), 32'h1E1E);
    get(1, 1'b1, v);
    chk("R10 lane1 high", 32'(v), 32'h4321);
    chk("R10 lane0 kept", 32'(ready_n[0]), 32'h0);
    get(0, 1'b1, v);
    chk("R10 lane0 high", 32'(v), 32'h0F0F);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_valid = '0;
    wr_word = '0;
    rd_en = '0;
    rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_empty();
    t_fill_overwrite();
    t_full_swap();
    t_lanes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule